// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Width

A synchronous true dual-port memory of 4096 bits. Each side has its own clock, enable, write strobe, address, write data and read data. The width of each side is a parameter (1, 2, 4, 8 or 16 bits). The number of addressable entries on that side is 4096 divided by the width. Both sides therefore see the same bit array through different shapes, so a value written as four narrow entries can be read back as one wide entry.

Every input is taken at the rising clock edge. Read data appears on the output register after that edge. A new address has no effect on the output until an edge captures it. A write also presents its own data on that side's output, so the port is write-first.

When both sides write bits that overlap on the same edge of port A's clock, the stored value is undefined and a collision flag rises. The flag is meant for the case where the two ports share one clock.

Top module: `dual_width_ram`

## Requirements
- R1: With width W the port has 4096/W entries and a log2(4096/W)-bit address. Its highest entry maps to the top W bits of the array.
- R2: A read, with enable high and write strobe low, puts the stored entry on that port's output on the edge that captures the address.
- R3: A write (enable and write strobe high) stores the data and shows that same data on that port's output after the edge.
- R4: While a port's enable is low it neither reads nor writes, and its output keeps its previous value.
- R5: A read leaves the stored contents unchanged, whatever is on the write-data input.
- R6: Entry a of a port with width W covers array bits a*W up to a*W+W-1, with the lowest bit of the data on the lowest array bit.
- R7: Changing a port's address between clock edges does not change its output.
- R8: The collision flag is high for the cycle after a port-A clock edge at which both ports write and their bit ranges overlap. It is low after edges where the ranges are disjoint or only one port writes.
- R9: While reset is held low, both outputs and the collision flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | log2(4096/WIDTH_A) | Port A entry address |
| a_din | input | WIDTH_A | Port A write data |
| a_dout | output | WIDTH_A | Port A read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write strobe |
| b_addr | input | log2(4096/WIDTH_B) | Port B entry address |
| b_din | input | WIDTH_B | Port B write data |
| b_dout | output | WIDTH_B | Port B read data |
| collision | output | 1 | Overlapping write on both ports, port A clock domain |

## Verification
The bench builds the block with port A 4 bits wide and port B 16 bits wide, with both ports on one clock. With this pairing, four nibble writes on port A can be checked as a single word on port B. The shapes are also unequal, which makes partial overlap possible: a nibble write can land inside a word write, or next to it. The top address on each side reaches the last nibble of the last word, which tests the depth boundary.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  localparam int TOTAL_BITS = 4096;
  localparam int PHYS_W     = 16;
  localparam int PHYS_WORDS = TOTAL_BITS / PHYS_W;
  localparam int BIT_AW     = $clog2(TOTAL_BITS);
  localparam int WORD_AW    = $clog2(PHYS_WORDS);
  localparam int LANE_AW    = $clog2(PHYS_W);

  function automatic bit legal_width(int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
  endfunction
endpackage

// File: rtl/dwr_rst_sync.sv
module dwr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/dwr_port.sv
module dwr_port
  import dwr_pkg::*;
#(
  parameter int W  = 4,
  localparam int DEPTH = TOTAL_BITS / W,
  localparam int AW    = $clog2(DEPTH),
  localparam int SH    = $clog2(W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [W-1:0]       din,
  output logic [W-1:0]       dout,
  output logic [WORD_AW-1:0] word_idx,
  input  logic [PHYS_W-1:0]  peer_word,
  input  logic [WORD_AW-1:0] peek_idx,
  output logic [PHYS_W-1:0]  peek_word
);
  if (!legal_width(W)) begin : g_bad_width
    $error("dwr_port: width must be 1, 2, 4, 8 or 16");
  end

  // This side's share of the XOR-coded storage; the array powers up clear.
  logic [PHYS_W-1:0]  plane [PHYS_WORDS] = '{default: '0};
  logic [BIT_AW-1:0]  bit_off;
  logic [LANE_AW-1:0] lane;
  logic [PHYS_W-1:0]  merged;
  logic [PHYS_W-1:0]  wr_word;
  logic [W-1:0]       dout_nxt;

  assign bit_off   = BIT_AW'(addr) << SH;
  assign word_idx  = bit_off[BIT_AW-1:LANE_AW];
  assign lane      = bit_off[LANE_AW-1:0];
  assign peek_word = plane[peek_idx];

  always_comb begin
    merged                = plane[word_idx] ^ peer_word;
    wr_word               = plane[word_idx];
    wr_word[lane +: W]    = din ^ peer_word[lane +: W];
    dout_nxt              = we ? din : merged[lane +: W];
  end

  always_ff @(posedge clk) begin
    if (en && we) plane[word_idx] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dout <= '0;
    else if (en) dout <= dout_nxt;
  end
endmodule

// File: rtl/dwr_collide.sv
module dwr_collide
  import dwr_pkg::*;
#(
  parameter int WA = 4,
  parameter int WB = 16,
  localparam int AWA = $clog2(TOTAL_BITS / WA),
  localparam int AWB = $clog2(TOTAL_BITS / WB),
  localparam int CW  = BIT_AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_a,
  input  logic           we_a,
  input  logic [AWA-1:0] addr_a,
  input  logic           en_b,
  input  logic           we_b,
  input  logic [AWB-1:0] addr_b,
  output logic           coll
);
  logic [CW-1:0] lo_a, hi_a, lo_b, hi_b;
  logic          overlap, coll_nxt;

  assign lo_a     = CW'(addr_a) << $clog2(WA);
  assign lo_b     = CW'(addr_b) << $clog2(WB);
  assign hi_a     = lo_a + CW'(WA);
  assign hi_b     = lo_b + CW'(WB);
  assign overlap  = (lo_a < hi_b) && (lo_b < hi_a);
  assign coll_nxt = en_a && we_a && en_b && we_b && overlap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coll <= 1'b0;
    else        coll <= coll_nxt;
  end
endmodule

// File: rtl/dual_width_ram.sv
module dual_width_ram
  import dwr_pkg::*;
#(
  parameter int WIDTH_A = 4,
  parameter int WIDTH_B = 16,
  localparam int AW_A = $clog2(TOTAL_BITS / WIDTH_A),
  localparam int AW_B = $clog2(TOTAL_BITS / WIDTH_B)
) (
  input  logic               clk_a,
  input  logic               clk_b,
  input  logic               rst_n,
  input  logic               a_en,
  input  logic               a_we,
  input  logic [AW_A-1:0]    a_addr,
  input  logic [WIDTH_A-1:0] a_din,
  output logic [WIDTH_A-1:0] a_dout,
  input  logic               b_en,
  input  logic               b_we,
  input  logic [AW_B-1:0]    b_addr,
  input  logic [WIDTH_B-1:0] b_din,
  output logic [WIDTH_B-1:0] b_dout,
  output logic               collision
);
  logic                rst_a_n, rst_b_n;
  logic [WORD_AW-1:0]  idx_a, idx_b;
  logic [PHYS_W-1:0]   word_of_a, word_of_b;

  dwr_rst_sync u_rst_a (.clk(clk_a), .rst_n(rst_n), .rst_n_sync(rst_a_n));
  dwr_rst_sync u_rst_b (.clk(clk_b), .rst_n(rst_n), .rst_n_sync(rst_b_n));

  dwr_port #(.W(WIDTH_A)) u_port_a (
    .clk(clk_a), .rst_n(rst_a_n), .en(a_en), .we(a_we), .addr(a_addr),
    .din(a_din), .dout(a_dout), .word_idx(idx_a),
    .peer_word(word_of_b), .peek_idx(idx_b), .peek_word(word_of_a)
  );

  dwr_port #(.W(WIDTH_B)) u_port_b (
    .clk(clk_b), .rst_n(rst_b_n), .en(b_en), .we(b_we), .addr(b_addr),
    .din(b_din), .dout(b_dout), .word_idx(idx_b),
    .peer_word(word_of_a), .peek_idx(idx_a), .peek_word(word_of_b)
  );

  dwr_collide #(.WA(WIDTH_A), .WB(WIDTH_B)) u_collide (
    .clk(clk_a), .rst_n(rst_a_n),
    .en_a(a_en), .we_a(a_we), .addr_a(a_addr),
    .en_b(b_en), .we_b(b_we), .addr_b(b_addr),
    .coll(collision)
  );
endmodule

// File: rtl/dual_width_ram_chk.sv
module dual_width_ram_chk
  import dwr_pkg::*;
#(
  parameter int WIDTH_A = 4,
  parameter int WIDTH_B = 16,
  localparam int AW_A = $clog2(TOTAL_BITS / WIDTH_A),
  localparam int AW_B = $clog2(TOTAL_BITS / WIDTH_B)
) (
  input logic               clk_a,
  input logic               clk_b,
  input logic               rst_n,
  input logic               a_en,
  input logic               a_we,
  input logic [AW_A-1:0]    a_addr,
  input logic [WIDTH_A-1:0] a_din,
  input logic [WIDTH_A-1:0] a_dout,
  input logic               b_en,
  input logic               b_we,
  input logic [AW_B-1:0]    b_addr,
  input logic [WIDTH_B-1:0] b_din,
  input logic [WIDTH_B-1:0] b_dout,
  input logic               collision
);
  AST_HOLD_A: assert property (@(posedge clk_a) disable iff (!rst_n)
    !a_en |=> $stable(a_dout)); // R4
  AST_HOLD_B: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_en |=> $stable(b_dout)); // R4
  AST_WRITE_FIRST_A: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_en && a_we) |=> (a_dout == $past(a_din))); // R3
  AST_WRITE_FIRST_B: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_en && b_we) |=> (b_dout == $past(b_din))); // R3
  AST_COLL_NEEDS_WRITES: assert property (@(posedge clk_a) disable iff (!rst_n)
    collision |-> $past(a_en && a_we && b_en && b_we)); // R8
endmodule

bind dual_width_ram dual_width_ram_chk #(.WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout),
  .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout),
  .collision(collision)
);

// File: tb/test_dual_width_ram.sv
module test_dual_width_ram;
  localparam int PERIOD = 10;
  localparam int WA = 4;
  localparam int WB = 16;
  localparam int AWA = 10;
  localparam int AWB = 8;

  logic           clk;
  logic           rst_n;
  logic           a_en, a_we, b_en, b_we;
  logic [AWA-1:0] a_addr;
  logic [AWB-1:0] b_addr;
  logic [WA-1:0]  a_din, a_dout;
  logic [WB-1:0]  b_din, b_dout;
  logic           collision;

  dual_width_ram #(.WIDTH_A(WA), .WIDTH_B(WB)) i_dual_width_ram (
    .clk_a(clk), .clk_b(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout),
    .collision(collision)
  );

  typedef struct {
    int          due;
    int          sel;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int    ncyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(input int sel);
    case (sel)
      0:       return {12'h000, a_dout};
      1:       return b_dout;
      default: return {15'h0000, collision};
    endcase
  endfunction

  // Monitor: compares each queued expectation at the negedge it is due.
  initial begin
    forever begin
      @(negedge clk);
      ncyc++;
      while (q.size() > 0 && q[0].due == ncyc) begin
        item_t it;
        it = q.pop_front();
        check(it.req, pick(it.sel), it.exp);
      end
    end
  end

  // Driver: sets inputs just after a negedge, captured at the following posedge.
  task automatic drive(input logic ea, input logic wa, input int aa, input int da,
                       input logic eb, input logic wb, input int ab, input int db);
    @(negedge clk);
    #1;
    a_en = ea; a_we = wa; a_addr = AWA'(aa); a_din = WA'(da);
    b_en = eb; b_we = wb; b_addr = AWB'(ab); b_din = WB'(db);
  endtask

  task automatic expect_at_next(input int sel, input logic [15:0] exp, input string req);
    item_t it;
    it.due = ncyc + 1; it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_en = 0; a_we = 0; a_addr = '0; a_din = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_din = '0;
    repeat (3) @(negedge clk);
    check("R9 a_dout", {12'h000, a_dout}, 16'h0000);
    check("R9 b_dout", b_dout, 16'h0000);
    check("R9 collision", {15'h0000, collision}, 16'h0000);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Clear B words 0 and 255 (R3 write-first on B)
    drive(0,0,0,0, 1,1,0,16'h0000);   expect_at_next(1, 16'h0000, "R3 b write");
    drive(0,0,0,0, 1,1,255,16'h0000); expect_at_next(1, 16'h0000, "R3 b write top");

    // Four nibble writes on A (R3), then one word read on B (R6)
    for (int i = 0; i < 4; i++) begin
      drive(1,1,i,5+i, 0,0,0,0); expect_at_next(0, 16'(5+i), "R3 a write");
    end
    drive(0,0,0,0, 1,0,0,0);   expect_at_next(1, 16'h8765, "R6 nibble order");

    // Plain reads on A (R2)
    drive(1,0,2,0, 0,0,0,0);   expect_at_next(0, 16'h0007, "R2 a read 2");
    drive(1,0,3,0, 0,0,0,0);   expect_at_next(0, 16'h0008, "R2 a read 3");

    // Address change with enable low, seen before the edge (R7) and after it (R4)
    drive(0,0,0,0, 0,0,0,0);
    #2 check("R7 addr change before edge", {12'h000, a_dout}, 16'h0008);
    expect_at_next(0, 16'h0008, "R4 hold after edge");

    // Disabled write is ignored (R4)
    drive(0,1,1,4'hF, 0,0,0,0); expect_at_next(0, 16'h0008, "R4 disabled write hold");
    drive(1,0,1,0, 0,0,0,0);    expect_at_next(0, 16'h0006, "R4 disabled write not stored");

    // Read with garbage write data leaves contents alone (R5)
    drive(0,0,0,0, 1,0,0,16'hFFFF); expect_at_next(1, 16'h8765, "R5 read output");
    drive(0,0,0,0, 1,0,0,0);        expect_at_next(1, 16'h8765, "R5 contents kept");

    // Highest entries (R1)
    drive(1,1,1023,9, 0,0,0,0); expect_at_next(0, 16'h0009, "R3 a write top");
    drive(0,0,0,0, 1,0,255,0);  expect_at_next(1, 16'h9000, "R1 top nibble in top word");
    drive(1,0,1023,0, 0,0,0,0); expect_at_next(0, 16'h0009, "R1 a read top");

    // Collision cases (R8)
    drive(1,1,4,1, 1,1,1,16'h0000);
    expect_at_next(2, 16'h0001, "R8 overlap flagged");
    expect_at_next(0, 16'h0001, "R3 a write-first in collision");
    expect_at_next(1, 16'h0000, "R3 b write-first in collision");
    drive(1,1,0,5, 1,1,1,16'h0000); expect_at_next(2, 16'h0000, "R8 disjoint writes");
    drive(1,1,7,2, 1,0,1,0);        expect_at_next(2, 16'h0000, "R8 single writer");
    drive(0,0,0,0, 1,0,1,0);        expect_at_next(1, 16'h2000, "R6 nibble 7 in word 1");

    drive(0,0,0,0, 0,0,0,0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule